// File: doc/BRIEF.md
# Successive Approximation Register Controller

This block is the digital sequencer of a successive-approximation A/D converter. A start pulse latches a channel number, one of nine analog inputs, and a resolution choice. The block then searches for the digital code of the held input, one bit per step, starting at the most significant bit. For each step it presents a 10-bit trial code to an external comparison-voltage generator. It reads back a single comparator bit that says whether the input lies above that trial level.

The same 10-bit approximation register serves both resolutions. In full mode the search runs down to bit 0. In short mode it stops once bit 2 is settled, so the two lowest bits stay at zero. Each step takes two clocks: the first presents the trial code and the second decides the bit. When the last bit is decided, the result register loads, a one-cycle done pulse is issued and the busy flag drops.

Top module: `sar_ctrl`

## Requirements
- R1: While rst_ni is low, busy_o, done_o, trial_o, result_o and chan_o are all 0.
- R2: A start_i seen at a clock edge while idle sets busy_o at that edge. The same edge latches the resolution and puts trial_o at 10'h200, with only bit 9 set.
- R3: On that start edge, chan_o takes chan_i when chan_i is 0 to 8, and 0 when chan_i is 9 to 15. chan_o stays constant while busy_o is high.
- R4: Each bit takes two cycles: one to present the code and one to decide. At the end of the deciding cycle, the bit under test stays 1 if cmp_i is 1 (input above trial) and is cleared otherwise. The next lower bit is then set in trial_o. The second trial code is 10'h300 when bit 9 was kept and 10'h100 when it was cleared.
- R5: With mode_short_i = 0 at start, all ten bits are resolved. done_o rises at the 20th clock edge after the start edge, and result_o is the largest code strictly below the input level (0 when none).
- R6: With mode_short_i = 1 at start, bits 9 to 2 are resolved. done_o rises at the 16th edge after the start edge, and result_o[1:0] = 0.
- R7: done_o is a single-cycle pulse. busy_o falls at the edge that raises done_o, and result_o changes only at that edge.
- R8: start_i, chan_i and mode_short_i are ignored while busy_o is high. They do not change chan_o, the result or the latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled at each rising edge |
| chan_i | input | 4 | Analog channel request, 0 to 8 valid |
| mode_short_i | input | 1 | 1 = 8-bit search (stop at bit 2), 0 = 10-bit |
| cmp_i | input | 1 | Comparator: 1 when the input is above the trial level |
| trial_o | output | 10 | Trial code to the comparison-voltage generator |
| chan_o | output | 4 | Channel latched for the conversion |
| result_o | output | 10 | Last conversion result |
| done_o | output | 1 | One-cycle pulse at the end of a conversion |
| busy_o | output | 1 | High from the start edge to the final decision |

## Verification
The comparator is modelled as an integer compare against an input level. Every level from 0 to 1024 is converted in both resolutions, and the result is checked against a code computed arithmetically for that level. The full sweep covers the ends of the range, where every decision goes the same way, and the midpoints, where bit 9 flips and so tells the 10'h100 and 10'h300 second trials apart. Levels just above multiples of four separate a search that stops at bit 2 from one that runs on. The channel request cycles through all sixteen values to hit the clamp. Some conversions receive a conflicting start, channel and mode in mid-flight; an unchanged result and latency then show that the request was ignored.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DRIVE  = 2'd1,
    PH_DECIDE = 2'd2
  } phase_e;
endpackage

// File: rtl/sar_chan_latch.sv
module sar_chan_latch #(
  parameter int CHAN_W   = 4,
  parameter int NUM_CHAN = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CHAN_W-1:0] chan_i,
  output logic [CHAN_W-1:0] chan_o
);
  localparam logic [CHAN_W-1:0] ChanLimit = CHAN_W'(NUM_CHAN);

  logic [CHAN_W-1:0] chan_q;
  logic [CHAN_W-1:0] chan_clamped;

  // out-of-range requests fall back to channel 0
  assign chan_clamped = (chan_i < ChanLimit) ? chan_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     chan_q <= '0;
    else if (load_i) chan_q <= chan_clamped;
  end

  assign chan_o = chan_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_ctrl_pkg::*;
#(
  parameter int CODE_W     = 10,
  parameter int PTR_W      = 4,
  parameter int SHORT_STOP = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             mode_short_i,
  output logic             load_o,
  output logic             decide_o,
  output logic             last_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             mode_short_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [PTR_W-1:0] TopPtr  = PTR_W'(CODE_W - 1);
  localparam logic [PTR_W-1:0] StopLow = PTR_W'(SHORT_STOP);

  phase_e           phase_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] stop_ptr;
  logic             mode_q;
  logic             done_q;

  assign load_o   = start_i && (phase_q == PH_IDLE);
  assign decide_o = (phase_q == PH_DECIDE);
  assign stop_ptr = mode_q ? StopLow : '0;
  assign last_o   = (ptr_q == stop_ptr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      ptr_q   <= '0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= decide_o && last_o;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q <= PH_DRIVE;
            ptr_q   <= TopPtr;
            mode_q  <= mode_short_i;
          end
        end
        PH_DRIVE: phase_q <= PH_DECIDE;
        PH_DECIDE: begin
          if (last_o) begin
            phase_q <= PH_IDLE;
          end else begin
            phase_q <= PH_DRIVE;
            ptr_q   <= ptr_q - 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign ptr_o        = ptr_q;
  assign mode_short_o = mode_q;
  assign busy_o       = (phase_q != PH_IDLE);
  assign done_o       = done_q;
endmodule

// File: rtl/sar_reg.sv
module sar_reg #(
  parameter int CODE_W = 10,
  parameter int PTR_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              decide_i,
  input  logic              last_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] code_o,
  output logic [CODE_W-1:0] result_o
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;
  logic [CODE_W-1:0] res_q;

  always_comb begin
    code_d = code_q;
    if (load_i) begin
      code_d             = '0;
      code_d[CODE_W-1]   = 1'b1;
    end else if (decide_i) begin
      for (int i = 0; i < CODE_W; i++) begin
        if (ptr_i == PTR_W'(i))
          code_d[i] = cmp_i;
        else if (!last_i && (ptr_i == PTR_W'(i + 1)))
          code_d[i] = 1'b1;  // arm next trial bit
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      res_q  <= '0;
    end else begin
      code_q <= code_d;
      if (decide_i && last_i) res_q <= code_d;
    end
  end

  assign code_o   = code_q;
  assign result_o = res_q;
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int CODE_W     = 10,
  parameter int CHAN_W     = 4,
  parameter int NUM_CHAN   = 9,
  parameter int SHORT_STOP = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic              mode_short_i,
  input  logic              cmp_i,
  output logic [CODE_W-1:0] trial_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic [CODE_W-1:0] result_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam int PTR_W = $clog2(CODE_W + 1);

  logic             load;
  logic             decide;
  logic             last;
  logic [PTR_W-1:0] ptr;
  logic             mode_short;

  sar_seq #(
    .CODE_W    (CODE_W),
    .PTR_W     (PTR_W),
    .SHORT_STOP(SHORT_STOP)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_short_i(mode_short_i),
    .load_o      (load),
    .decide_o    (decide),
    .last_o      (last),
    .ptr_o       (ptr),
    .mode_short_o(mode_short),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  sar_reg #(
    .CODE_W(CODE_W),
    .PTR_W (PTR_W)
  ) i_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .decide_i(decide),
    .last_i  (last),
    .ptr_i   (ptr),
    .cmp_i   (cmp_i),
    .code_o  (trial_o),
    .result_o(result_o)
  );

  sar_chan_latch #(
    .CHAN_W  (CHAN_W),
    .NUM_CHAN(NUM_CHAN)
  ) i_chan (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .chan_i(chan_i),
    .chan_o(chan_o)
  );
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int CODE_W     = 10,
  parameter int CHAN_W     = 4,
  parameter int NUM_CHAN   = 9,
  parameter int SHORT_STOP = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] trial_o,
  input logic [CHAN_W-1:0] chan_o,
  input logic [CODE_W-1:0] result_o,
  input logic              done_o,
  input logic              busy_o,
  input logic              mode_short
);
  localparam logic [CODE_W-1:0] FirstTrial = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CHAN_W-1:0] ChanMax    = CHAN_W'(NUM_CHAN - 1);

  // R2
  first_trial_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> trial_o == FirstTrial);

  // R3
  chan_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_o <= ChanMax);

  // R3
  chan_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(chan_o));

  // R6
  short_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_short) |-> result_o[SHORT_STOP-1:0] == '0);

  // R7
  done_ends_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);
endmodule

bind sar_ctrl sar_ctrl_chk #(
  .CODE_W    (CODE_W),
  .CHAN_W    (CHAN_W),
  .NUM_CHAN  (NUM_CHAN),
  .SHORT_STOP(SHORT_STOP)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .trial_o   (trial_o),
  .chan_o    (chan_o),
  .result_o  (result_o),
  .done_o    (done_o),
  .busy_o    (busy_o),
  .mode_short(mode_short)
);

// File: tb/test_sar_ctrl.sv
`timescale 1ns/1ps
module test_sar_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] chan_i = '0;
  logic       mode_short_i = 1'b0;
  logic       cmp_i;
  logic [9:0] trial_o;
  logic [3:0] chan_o;
  logic [9:0] result_o;
  logic       done_o;
  logic       busy_o;

  int vin_lvl = 0;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  // comparator model: input strictly above the trial level
  assign cmp_i = (vin_lvl > int'(trial_o));

  sar_ctrl i_sar_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .chan_i      (chan_i),
    .mode_short_i(mode_short_i),
    .cmp_i       (cmp_i),
    .trial_o     (trial_o),
    .chan_o      (chan_o),
    .result_o    (result_o),
    .done_o      (done_o),
    .busy_o      (busy_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic convert(input int vin, input bit short_m, input logic [3:0] ch, input bit poke);
    int n;
    int exp_res;
    int exp_lat;
    int exp_ch;
    bit busy_ok;
    vin_lvl = vin;
    exp_ch  = (ch > 4'd8) ? 0 : int'(ch);
    exp_lat = short_m ? 16 : 20;
    if (vin == 0) exp_res = 0;
    else if (short_m) exp_res = ((vin - 1) >> 2) << 2;
    else exp_res = (vin - 1 > 1023) ? 1023 : vin - 1;
    @(negedge clk_i);
    chan_i = ch; mode_short_i = short_m; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    check("R2 busy after start", int'(busy_o), 1);
    check("R2 first trial", int'(trial_o), 512);
    check("R3 channel latch", int'(chan_o), exp_ch);
    n = 0;
    busy_ok = 1'b1;
    while (1) begin
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
      if (poke && n == 5) begin
        start_i = 1'b1; chan_i = ch ^ 4'h3; mode_short_i = !short_m;
      end else if (poke && n == 6) begin
        start_i = 1'b0;
      end
      if (n == 2) check("R4 second trial", int'(trial_o), (vin > 512) ? 768 : 256);
      if (done_o) break;
      if (!busy_o) busy_ok = 1'b0;
      if (n > 40) break;
    end
    check("R7 busy held until done", int'(busy_ok), 1);
    check(short_m ? "R6 latency" : "R5 latency", n, exp_lat);
    check(short_m ? "R6 result" : "R5 result", int'(result_o), exp_res);
    check("R7 busy low at done", int'(busy_o), 0);
    check(poke ? "R8 channel kept" : "R3 channel held", int'(chan_o), exp_ch);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R7 done single pulse", int'(done_o), 0);
    check("R7 result held", int'(result_o), exp_res);
  endtask

  initial begin
    #2;
    check("R1 busy in reset", int'(busy_o), 0);
    check("R1 done in reset", int'(done_o), 0);
    check("R1 trial in reset", int'(trial_o), 0);
    check("R1 result in reset", int'(result_o), 0);
    check("R1 chan in reset", int'(chan_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 idle after reset", int'(busy_o), 0);

    for (int v = 0; v <= 1024; v++) convert(v, 1'b0, 4'(v % 16), (v % 37) == 5);
    for (int v = 0; v <= 1024; v++) convert(v, 1'b1, 4'((v * 7) % 16), (v % 41) == 3);

    // reset in mid-conversion
    vin_lvl = 700;
    @(negedge clk_i);
    chan_i = 4'd6; mode_short_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (7) @(negedge clk_i);
    rst_ni = 1'b0;
    #2;
    check("R1 busy cleared", int'(busy_o), 0);
    check("R1 trial cleared", int'(trial_o), 0);
    check("R1 result cleared", int'(result_o), 0);
    check("R1 chan cleared", int'(chan_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule